// File: doc/BRIEF.md
# Exception internal header generator

This block sits after the forwarding lookup of a routing engine. For each packet it takes the lookup result flags, the exception bits raised by header parsing, the receive and transmit meta-interface IDs, the output port, the queue ID and an optional next-hop address. From these it decides where the packet goes. It can be discarded, sent on the fast path to an egress line card or to another routing engine, or handed to the control engine with a numbered reason. It then builds the internal header that the downstream stages put in front of the packet.

Each internal header starts with a type byte, a length byte and the 16-bit RxMI. Some types then carry a forwarding key: the TxMI, followed by a 32-bit next-hop address when the next hop sits on a multi-access link. Packets bound for a line card carry no header. The result is registered once and appears on the outputs one cycle after the input is accepted. Queueing and encapsulation are handled elsewhere.

Top module: `exhdr_gen`

## Requirements
- R1: A packet presented with drop set produces no output: valid_o stays low in the following cycle, whatever the other flags are.
- R2: The reason is chosen in fixed priority. From highest to lowest: forwarding-key error (type 0x0a), TTL expired (0x04), IP options (0x05), no route when hit is clear (0x03), local delivery (0x08), RxMI equal to TxMI (0x06), then fast path (0x02, or line card).
- R3: Header byte k sits on hdr_o[8k+7:8k]. Byte 0 is the type, byte 1 is the length and bytes 2..3 are RxMI, high byte first.
- R4: Types 0x02, 0x05 and 0x06 carry the forwarding key. TxMI is placed in bytes 4..5, high byte first. When nh is set, the next-hop address follows in bytes 6..9, high byte first. The length is 6 without nh and 10 with it.
- R5: Types 0x03, 0x04, 0x08 and 0x0a carry only RxMI, with a length of 4. Every header byte at or beyond the length reads zero.
- R6: A fast-path packet with mac set goes to the egress line card (dest code 0). Its length is 0 and its header is all zero.
- R7: dest_o is 2 (control engine) for types 0x03 to 0x0a and 1 (routing engine) for the fast-path type 0x02.
- R8: valid_o rises exactly one cycle after an accepted valid_i. port_o and qid_o then equal the values presented with it. With valid_i low, valid_o is low in the next cycle.
- R9: After reset, valid_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input descriptor present |
| hit_i | input | 1 | Lookup hit |
| drop_i | input | 1 | Lookup asks for discard |
| nh_i | input | 1 | Next-hop address present (multi-access link) |
| mac_i | input | 1 | MAC address needed, egress via line card |
| ld_i | input | 1 | Local delivery |
| ttl_exc_i | input | 1 | Parse exception: TTL 0 or 1 |
| opt_exc_i | input | 1 | Parse exception: IP options present |
| key_err_i | input | 1 | Forwarding key invalid |
| port_i | input | 4 | Output port |
| qid_i | input | 20 | Queue ID |
| rxmi_i | input | 16 | Receive meta-interface |
| txmi_i | input | 16 | Transmit meta-interface |
| nh_addr_i | input | 32 | Next-hop address |
| valid_o | output | 1 | Result present |
| hdr_o | output | 80 | Header bytes, byte k at bits 8k+7:8k |
| len_o | output | 4 | Header length in bytes |
| type_o | output | 8 | Internal header type |
| dest_o | output | 2 | 0 line card, 1 routing engine, 2 control engine |
| port_o | output | 4 | Output port |
| qid_o | output | 20 | Queue ID |

## Verification
Several exception reasons often fall on the same packet. A TTL expiry can coincide with options, a miss, local delivery and a same-interface redirect, and a drop can arrive on top of any of them. The bench sweeps all 512 combinations of the nine decision inputs. In the combinations that set the eq bit it forces TxMI equal to RxMI. Every result is compared with a priority model computed in the bench: only the highest-ranked reason may set the type, the payload and the length, and a drop must suppress the result entirely.

// File: rtl/exhdr_pkg.sv
package exhdr_pkg;
  localparam logic [7:0] T_FAST     = 8'h02;
  localparam logic [7:0] T_NOROUTE  = 8'h03;
  localparam logic [7:0] T_TTL      = 8'h04;
  localparam logic [7:0] T_OPTS     = 8'h05;
  localparam logic [7:0] T_REDIRECT = 8'h06;
  localparam logic [7:0] T_LOCAL    = 8'h08;
  localparam logic [7:0] T_DEBUG    = 8'h0a;

  typedef enum logic [1:0] {
    DEST_LC     = 2'd0,
    DEST_ENGINE = 2'd1,
    DEST_CTRL   = 2'd2
  } dest_e;

  typedef struct packed {
    logic [7:0] code;
    logic       key;
    dest_e      dest;
  } reason_t;
endpackage

// File: rtl/exhdr_reason.sv
module exhdr_reason
  import exhdr_pkg::*;
(
  input  logic    key_err_i,
  input  logic    ttl_i,
  input  logic    opt_i,
  input  logic    hit_i,
  input  logic    ld_i,
  input  logic    mi_eq_i,
  input  logic    mac_i,
  output reason_t rsn_o
);
  always_comb begin
    if (key_err_i)     rsn_o = '{code: T_DEBUG,    key: 1'b0, dest: DEST_CTRL};
    else if (ttl_i)    rsn_o = '{code: T_TTL,      key: 1'b0, dest: DEST_CTRL};
    else if (opt_i)    rsn_o = '{code: T_OPTS,     key: 1'b1, dest: DEST_CTRL};
    else if (!hit_i)   rsn_o = '{code: T_NOROUTE,  key: 1'b0, dest: DEST_CTRL};
    else if (ld_i)     rsn_o = '{code: T_LOCAL,    key: 1'b0, dest: DEST_CTRL};
    else if (mi_eq_i)  rsn_o = '{code: T_REDIRECT, key: 1'b1, dest: DEST_CTRL};
    else if (mac_i)    rsn_o = '{code: T_FAST,     key: 1'b0, dest: DEST_LC};
    else               rsn_o = '{code: T_FAST,     key: 1'b1, dest: DEST_ENGINE};
  end
endmodule

// File: rtl/exhdr_pack.sv
module exhdr_pack
  import exhdr_pkg::*;
#(
  parameter int MI_W      = 16,
  parameter int NH_W      = 32,
  parameter int HDR_BYTES = 10,
  parameter int LEN_W     = 4
) (
  input  reason_t                rsn_i,
  input  logic                   nh_i,
  input  logic [MI_W-1:0]        rxmi_i,
  input  logic [MI_W-1:0]        txmi_i,
  input  logic [NH_W-1:0]        nh_addr_i,
  output logic [HDR_BYTES*8-1:0] hdr_o,
  output logic [LEN_W-1:0]       len_o
);
  localparam int MI_B    = MI_W / 8;
  localparam int NH_B    = NH_W / 8;
  localparam int BASE_B  = 2 + MI_B;
  localparam int KEY_B   = BASE_B + MI_B;

  logic [HDR_BYTES*8-1:0] full;

  always_comb begin
    if (rsn_i.dest == DEST_LC) len_o = '0;
    else if (rsn_i.key)        len_o = nh_i ? LEN_W'(KEY_B + NH_B) : LEN_W'(KEY_B);
    else                       len_o = LEN_W'(BASE_B);
  end

  // byte 0 at the top of the flat vector
  assign full = {rsn_i.code, 8'(len_o), rxmi_i, txmi_i, nh_addr_i};

  for (genvar k = 0; k < HDR_BYTES; k++) begin : g_byte
    assign hdr_o[k*8 +: 8] = (k < int'(len_o)) ? full[(HDR_BYTES-1-k)*8 +: 8] : 8'h00;
  end
endmodule

// File: rtl/exhdr_gen.sv
module exhdr_gen
  import exhdr_pkg::*;
#(
  parameter int PORT_W = 4,
  parameter int QID_W  = 20,
  parameter int MI_W   = 16,
  parameter int NH_W   = 32,
  localparam int HDR_BYTES = 2 + 2*(MI_W/8) + NH_W/8,
  localparam int LEN_W     = $clog2(HDR_BYTES + 1)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   valid_i,
  input  logic                   hit_i,
  input  logic                   drop_i,
  input  logic                   nh_i,
  input  logic                   mac_i,
  input  logic                   ld_i,
  input  logic                   ttl_exc_i,
  input  logic                   opt_exc_i,
  input  logic                   key_err_i,
  input  logic [PORT_W-1:0]      port_i,
  input  logic [QID_W-1:0]       qid_i,
  input  logic [MI_W-1:0]        rxmi_i,
  input  logic [MI_W-1:0]        txmi_i,
  input  logic [NH_W-1:0]        nh_addr_i,
  output logic                   valid_o,
  output logic [HDR_BYTES*8-1:0] hdr_o,
  output logic [LEN_W-1:0]       len_o,
  output logic [7:0]             type_o,
  output logic [1:0]             dest_o,
  output logic [PORT_W-1:0]      port_o,
  output logic [QID_W-1:0]       qid_o
);
  reason_t                rsn;
  logic [HDR_BYTES*8-1:0] hdr_d;
  logic [LEN_W-1:0]       len_d;
  logic                   accept;

  assign accept = valid_i && !drop_i;

  exhdr_reason u_reason (
    .key_err_i (key_err_i),
    .ttl_i     (ttl_exc_i),
    .opt_i     (opt_exc_i),
    .hit_i     (hit_i),
    .ld_i      (ld_i),
    .mi_eq_i   (rxmi_i == txmi_i),
    .mac_i     (mac_i),
    .rsn_o     (rsn)
  );

  exhdr_pack #(
    .MI_W      (MI_W),
    .NH_W      (NH_W),
    .HDR_BYTES (HDR_BYTES),
    .LEN_W     (LEN_W)
  ) u_pack (
    .rsn_i     (rsn),
    .nh_i      (nh_i),
    .rxmi_i    (rxmi_i),
    .txmi_i    (txmi_i),
    .nh_addr_i (nh_addr_i),
    .hdr_o     (hdr_d),
    .len_o     (len_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_o <= 1'b0;
    else         valid_o <= accept;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hdr_o  <= '0;
      len_o  <= '0;
      type_o <= '0;
      dest_o <= '0;
      port_o <= '0;
      qid_o  <= '0;
    end else if (accept) begin
      hdr_o  <= hdr_d;
      len_o  <= len_d;
      type_o <= rsn.code;
      dest_o <= rsn.dest;
      port_o <= port_i;
      qid_o  <= qid_i;
    end
  end

  assert_drop_silent_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && drop_i |=> !valid_o);

  assert_ttl_beats_lower_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !drop_i && !key_err_i && ttl_exc_i |=> type_o == T_TTL);

  assert_hdr_prefix_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && len_o != '0 |-> hdr_o[7:0] == type_o && hdr_o[15:8] == 8'(len_o));

  assert_len_legal_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && dest_o != DEST_LC |->
      (len_o == LEN_W'(4) || len_o == LEN_W'(6) || len_o == LEN_W'(10)));

  assert_lc_empty_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && dest_o == DEST_LC |-> len_o == '0 && hdr_o == '0);

  assert_ctrl_types_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && dest_o == DEST_CTRL |-> type_o >= T_NOROUTE && type_o <= T_DEBUG);

  assert_one_cycle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !drop_i |=> valid_o && qid_o == $past(qid_i));
endmodule

// File: tb/exhdr_gen_test.sv
`timescale 1ns/1ps
module exhdr_gen_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0, hit_i = 1'b0, drop_i = 1'b0, nh_i = 1'b0, mac_i = 1'b0;
  logic        ld_i = 1'b0, ttl_exc_i = 1'b0, opt_exc_i = 1'b0, key_err_i = 1'b0;
  logic [3:0]  port_i = '0;
  logic [19:0] qid_i = '0;
  logic [15:0] rxmi_i = '0, txmi_i = '0;
  logic [31:0] nh_addr_i = '0;
  logic        valid_o;
  logic [79:0] hdr_o;
  logic [3:0]  len_o;
  logic [7:0]  type_o;
  logic [1:0]  dest_o;
  logic [3:0]  port_o;
  logic [19:0] qid_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  exhdr_gen uut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .hit_i(hit_i), .drop_i(drop_i),
    .nh_i(nh_i), .mac_i(mac_i), .ld_i(ld_i), .ttl_exc_i(ttl_exc_i), .opt_exc_i(opt_exc_i),
    .key_err_i(key_err_i), .port_i(port_i), .qid_i(qid_i), .rxmi_i(rxmi_i), .txmi_i(txmi_i),
    .nh_addr_i(nh_addr_i), .valid_o(valid_o), .hdr_o(hdr_o), .len_o(len_o), .type_o(type_o),
    .dest_o(dest_o), .port_o(port_o), .qid_o(qid_o)
  );

  task automatic check(input string req, input logic [79:0] act, input logic [79:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0]  e_type;
    logic        e_key;
    logic [1:0]  e_dest;
    logic [3:0]  e_len;
    logic [79:0] e_hdr;
    logic [7:0]  full [10];

    repeat (3) @(negedge clk);
    check("R9 reset valid", 80'(valid_o), 80'd0);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R8 idle", 80'(valid_o), 80'd0);

    for (int v = 0; v < 512; v++) begin
      // v bits: 8 drop,7 key_err,6 ttl,5 opt,4 hit,3 ld,2 eq,1 mac,0 nh
      valid_i   = 1'b1;
      drop_i    = v[8];
      key_err_i = v[7];
      ttl_exc_i = v[6];
      opt_exc_i = v[5];
      hit_i     = v[4];
      ld_i      = v[3];
      mac_i     = v[1];
      nh_i      = v[0];
      rxmi_i    = 16'hA500 ^ 16'(v * 3);
      txmi_i    = v[2] ? rxmi_i : (rxmi_i ^ 16'h0F0F);
      nh_addr_i = 32'hC0A8_0000 | 32'(v * 257);
      qid_i     = 20'(v * 2039);
      port_i    = 4'(v);

      // priority model (R2)
      if (v[7])       begin e_type = 8'h0a; e_key = 0; e_dest = 2; end
      else if (v[6])  begin e_type = 8'h04; e_key = 0; e_dest = 2; end
      else if (v[5])  begin e_type = 8'h05; e_key = 1; e_dest = 2; end
      else if (!v[4]) begin e_type = 8'h03; e_key = 0; e_dest = 2; end
      else if (v[3])  begin e_type = 8'h08; e_key = 0; e_dest = 2; end
      else if (v[2])  begin e_type = 8'h06; e_key = 1; e_dest = 2; end
      else if (v[1])  begin e_type = 8'h02; e_key = 0; e_dest = 0; end
      else            begin e_type = 8'h02; e_key = 1; e_dest = 1; end

      if (e_dest == 0) e_len = 0;
      else if (e_key)  e_len = v[0] ? 4'd10 : 4'd6;
      else             e_len = 4'd4;

      full[0] = e_type;          full[1] = 8'(e_len);
      full[2] = rxmi_i[15:8];    full[3] = rxmi_i[7:0];
      full[4] = txmi_i[15:8];    full[5] = txmi_i[7:0];
      full[6] = nh_addr_i[31:24]; full[7] = nh_addr_i[23:16];
      full[8] = nh_addr_i[15:8];  full[9] = nh_addr_i[7:0];
      e_hdr = '0;
      for (int k = 0; k < 10; k++)
        if (k < int'(e_len)) e_hdr[k*8 +: 8] = full[k];

      @(posedge clk);
      @(negedge clk);
      if (v[8]) begin
        check("R1 drop silent", 80'(valid_o), 80'd0);
      end else begin
        check("R8 valid", 80'(valid_o), 80'd1);
        check("R8 qid", 80'(qid_o), 80'(qid_i));
        check("R8 port", 80'(port_o), 80'(port_i));
        check("R2 type", 80'(type_o), 80'(e_type));
        check(e_dest == 0 ? "R6 dest" : "R7 dest", 80'(dest_o), 80'(e_dest));
        check(e_dest == 0 ? "R6 len" : (e_key ? "R4 len" : "R5 len"), 80'(len_o), 80'(e_len));
        check(e_dest == 0 ? "R6 hdr" : (e_key ? "R4 hdr" : "R3 R5 hdr"), hdr_o, e_hdr);
      end
    end

    valid_i = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check("R8 idle after run", 80'(valid_o), 80'd0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule